// File: doc/BRIEF.md
# T1 Transmit Channel Byte Processor

This block sits in the transmit path of a 24-channel T1 framer, ahead of the serializer. For every outgoing 8-bit channel slot it receives the channel number, the frame number within a 12-frame superframe, the payload byte and the channel's signaling bit. It returns the byte that goes on the line. Per-channel masks held in a small write port choose which channels are clear (transparent) and which carry a programmable idle code in place of their payload.

The processing order for each byte is fixed. First the idle code replaces the payload on channels marked idle. Next, in signaling frames, the signaling bit goes into the least significant bit of non-clear channels. Then an all-zero byte on a non-clear channel has 0x02 set. Last, while a yellow alarm is sent in D4 mode, bit value 0x40 is cleared on every channel. Two override inputs, when both high, apply the zero fix-up to clear channels as well. Framing bits, line coding and serialization are handled elsewhere.

Top module: `t1_ds0_proc`

## Requirements
- R1: Writing with `cfg_we` high stores `cfg_wdata` at `cfg_addr`. Addresses 0..2 are the clear masks and 3..5 are the idle masks: channel n (1..24) is bit (n-1)%8 of mask byte (n-1)/8. Address 6 holds the idle code. A slot presented in the same cycle as a write still uses the old values, and the next slot uses the new ones.
- R2: On a channel whose idle bit is 1, the payload is replaced by the idle code, with code bit 7 as the byte MSB.
- R3: On a clear channel, with the stuffing override off and no D4 yellow alarm, the output equals the idle-or-payload byte unchanged: no signaling bit is inserted and no stuffing is done.
- R4: On a non-clear channel in frame 6 or frame 12, output bit 0 (value 0x01) takes `slot_sig`. In any other frame the bit is left as it is.
- R5: On a non-clear channel, a byte that is 0x00 after idle substitution and signaling insertion is sent as 0x02.
- R6: When `stuff_all_a` and `stuff_all_b` are both 1, the rule of R5 applies to clear channels too, and clear channels still get no signaling bit. With only one of the two high, there is no such effect.
- R7: When `d4_mode` and `yellow_tx` are both 1, output bit 6 (value 0x40) is 0 on every channel, clear ones included. With `d4_mode` at 0, `yellow_tx` has no effect.
- R8: The steps run in the order idle, signaling, stuffing, yellow. A byte that is emptied only by the yellow override is therefore sent as 0x00, not 0x02.
- R9: `out_valid` is high exactly one clock after `slot_valid` was high. `out_data` changes only when `out_valid` rises with a new slot, and holds its value otherwise.
- R10: After reset, `out_valid` and `out_data` are 0 and every mask and the idle code are 0, so every channel is non-clear and not idle.
- R11: A channel number outside 1..24 is treated as neither clear nor idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0..2 clear masks, 3..5 idle masks, 6 idle code) |
| cfg_wdata | input | 8 | Register write data |
| slot_valid | input | 1 | A channel slot is presented this cycle |
| slot_chan | input | 5 | Channel number, 1..24 |
| slot_frame | input | 4 | Frame number in the superframe, 1..12 |
| slot_data | input | 8 | Payload byte |
| slot_sig | input | 1 | Signaling bit for this channel |
| d4_mode | input | 1 | D4 framing selected |
| yellow_tx | input | 1 | Yellow alarm being sent |
| stuff_all_a | input | 1 | First control of the force-stuffing override |
| stuff_all_b | input | 1 | Second control of the force-stuffing override |
| out_valid | output | 1 | Processed byte valid |
| out_data | output | 8 | Processed channel byte |

## Verification
Two pairs of functions can act on the same byte in one slot. A register write can arrive in the same cycle as a slot on the channel it changes: the bench drives a clear-mask write together with a signaling-frame slot and expects the old result, then sends a second slot and expects the new one. Stuffing and the yellow override can also meet on one byte. The bench sends 0x40 with D4 yellow active and expects 0x00, and it sends an idle code of 0x01 in a signaling frame with the signaling bit 0 and expects 0x02. These two results are only right if the steps run in the order stated in R8.

// File: rtl/t1dp_pkg.sv
package t1dp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_SIG = 0;  // robbed position, value 0x01
  localparam int unsigned BIT_STUFF = 1;  // zero fix-up position, value 0x02
  localparam int unsigned BIT_YEL = 6;  // alarm position, value 0x40

  typedef logic [BYTE_W-1:0] ds0_t;

  typedef struct packed {
    logic use_idle;
    logic sig_en;
    logic stuff_en;
    logic yel_en;
  } slot_ctl_t;
endpackage

// File: rtl/t1dp_regs.sv
module t1dp_regs #(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  t1dp_pkg::ds0_t             wdata,
  output logic [NUM_CH-1:0]          clear_map,
  output logic [NUM_CH-1:0]          idle_map,
  output t1dp_pkg::ds0_t             idle_code
);
  import t1dp_pkg::*;
  localparam int unsigned NUM_MB = NUM_CH / BYTE_W;
  localparam logic [ADDR_W-1:0] CODE_ADDR = ADDR_W'(2 * NUM_MB);

  ds0_t clear_q [NUM_MB];
  ds0_t idle_q  [NUM_MB];
  ds0_t clear_d [NUM_MB];
  ds0_t idle_d  [NUM_MB];
  ds0_t code_q, code_d;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(g);
    localparam logic [ADDR_W-1:0] A_IDL = ADDR_W'(NUM_MB + g);

    always_comb begin
      clear_d[g] = clear_q[g];
      idle_d[g]  = idle_q[g];
      if (we && addr == A_CLR) clear_d[g] = wdata;
      if (we && addr == A_IDL) idle_d[g]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clear_q[g] <= '0;
        idle_q[g]  <= '0;
      end else begin
        clear_q[g] <= clear_d[g];
        idle_q[g]  <= idle_d[g];
      end
    end

    assign clear_map[g*BYTE_W +: BYTE_W] = clear_q[g];
    assign idle_map[g*BYTE_W +: BYTE_W]  = idle_q[g];
  end

  always_comb begin
    code_d = code_q;
    if (we && addr == CODE_ADDR) code_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign idle_code = code_q;

  // R1: a write to the code address is visible on the next cycle
  a_r1_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CODE_ADDR) |=> (idle_code == $past(wdata)));
endmodule

// File: rtl/t1dp_chan_sel.sv
module t1dp_chan_sel #(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned CH_W   = 5
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [NUM_CH-1:0] clear_map,
  input  logic [NUM_CH-1:0] idle_map,
  output logic              is_clear,
  output logic              is_idle
);
  always_comb begin
    is_clear = 1'b0;
    is_idle  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan == CH_W'(i + 1)) begin
        is_clear = clear_map[i];
        is_idle  = idle_map[i];
      end
    end
  end
endmodule

// File: rtl/t1dp_byte_path.sv
module t1dp_byte_path (
  input  t1dp_pkg::ds0_t      data_in,
  input  t1dp_pkg::ds0_t      idle_code,
  input  logic                sig_bit,
  input  t1dp_pkg::slot_ctl_t ctl,
  output t1dp_pkg::ds0_t      data_out
);
  import t1dp_pkg::*;
  ds0_t s_idle, s_sig, s_stuff;

  always_comb begin
    s_idle = ctl.use_idle ? idle_code : data_in;
    s_sig  = s_idle;
    if (ctl.sig_en) s_sig[BIT_SIG] = sig_bit;
    s_stuff = s_sig;
    if (ctl.stuff_en && s_sig == '0) s_stuff[BIT_STUFF] = 1'b1;
    data_out = s_stuff;
    if (ctl.yel_en) data_out[BIT_YEL] = 1'b0;
  end
endmodule

// File: rtl/t1_ds0_proc.sv
module t1_ds0_proc #(
  parameter int unsigned NUM_CH  = 24,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned FRM_W   = 4,
  parameter int unsigned SIG_FRM_A = 6,
  parameter int unsigned SIG_FRM_B = 12,
  localparam int unsigned CH_W   = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              slot_valid,
  input  logic [CH_W-1:0]   slot_chan,
  input  logic [FRM_W-1:0]  slot_frame,
  input  logic [7:0]        slot_data,
  input  logic              slot_sig,
  input  logic              d4_mode,
  input  logic              yellow_tx,
  input  logic              stuff_all_a,
  input  logic              stuff_all_b,
  output logic              out_valid,
  output logic [7:0]        out_data
);
  import t1dp_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_CH-1:0] clear_map, idle_map;
  ds0_t              idle_code;
  logic              is_clear, is_idle;
  logic              sig_frame, force_stuff, yel_on;
  slot_ctl_t         ctl;
  ds0_t              proc_byte;
  ds0_t              data_d;
  logic              valid_d;

  t1dp_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .clear_map(clear_map), .idle_map(idle_map),
    .idle_code(idle_code)
  );

  t1dp_chan_sel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .chan(slot_chan), .clear_map(clear_map), .idle_map(idle_map),
    .is_clear(is_clear), .is_idle(is_idle)
  );

  always_comb begin
    sig_frame    = (slot_frame == FRM_W'(SIG_FRM_A)) || (slot_frame == FRM_W'(SIG_FRM_B));
    force_stuff  = stuff_all_a && stuff_all_b;
    yel_on       = d4_mode && yellow_tx;
    ctl.use_idle = is_idle;
    ctl.sig_en   = !is_clear && sig_frame;
    ctl.stuff_en = !is_clear || force_stuff;
    ctl.yel_en   = yel_on;
  end

  t1dp_byte_path u_path (
    .data_in(slot_data), .idle_code(idle_code), .sig_bit(slot_sig),
    .ctl(ctl), .data_out(proc_byte)
  );

  always_comb begin
    valid_d = slot_valid;
    data_d  = out_data;
    if (slot_valid) data_d = proc_byte;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_d;
      out_data  <= data_d;
    end
  end

  // R9: one-cycle latency, output held between slots
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    slot_valid |=> out_valid);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !slot_valid |=> (!out_valid && $stable(out_data)));
  // R7: alarm bit cleared whenever D4 yellow is active
  a_r7_yellow_bit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_valid && d4_mode && yellow_tx) |=> !out_data[BIT_YEL]);
  // R5 / R6: a stuffed channel never emits an all-zero byte without yellow
  a_r5_no_zero_byte: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_valid && (!is_clear || (stuff_all_a && stuff_all_b)) && !(d4_mode && yellow_tx))
      |=> (out_data != '0));
  // R3: clear, non-idle channel passes untouched
  a_r3_clear_pass: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_valid && is_clear && !is_idle && !(stuff_all_a && stuff_all_b)
      && !(d4_mode && yellow_tx)) |=> (out_data == $past(slot_data)));
endmodule

// File: tb/t1_ds0_proc_test.sv
module t1_ds0_proc_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       slot_valid;
  logic [4:0] slot_chan;
  logic [3:0] slot_frame;
  logic [7:0] slot_data;
  logic       slot_sig, d4_mode, yellow_tx, stuff_all_a, stuff_all_b;
  logic       out_valid;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  t1_ds0_proc uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slot_valid(slot_valid), .slot_chan(slot_chan),
    .slot_frame(slot_frame), .slot_data(slot_data), .slot_sig(slot_sig),
    .d4_mode(d4_mode), .yellow_tx(yellow_tx), .stuff_all_a(stuff_all_a),
    .stuff_all_b(stuff_all_b), .out_valid(out_valid), .out_data(out_data)
  );

  // {chan[5], frame[4], data[8], sig, d4, yel, ova, ovb, expected[8]} = 30 bits
  localparam int NV = 18;
  localparam logic [29:0] VEC [NV] = '{
    {5'd3,  4'd1,  8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A}, // R4 no-sig frame
    {5'd3,  4'd6,  8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5B}, // R4 frame 6
    {5'd3,  4'd12, 8'h5B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A}, // R4 frame 12
    {5'd3,  4'd3,  8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R5
    {5'd1,  4'd6,  8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 ch1
    {5'd5,  4'd12, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81}, // R3 ch5
    {5'd2,  4'd1,  8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C}, // R2
    {5'd7,  4'd6,  8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3D}, // R2 + sig
    {5'd24, 4'd6,  8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C}, // R1 ch24 idle+clear
    {5'd1,  4'd1,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02}, // R6 forced
    {5'd1,  4'd1,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R6 one control
    {5'd1,  4'd6,  8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02}, // R6 no sig on clear
    {5'd1,  4'd1,  8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hBF}, // R7 clear ch
    {5'd3,  4'd1,  8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF}, // R7 not D4
    {5'd3,  4'd1,  8'h40, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R8 yellow last
    {5'd0,  4'd6,  8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R11 ch0
    {5'd31, 4'd1,  8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R11 ch31
    {5'd8,  4'd6,  8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01}  // R1 ch8 not clear
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_slot(input string req, input logic [29:0] v);
    @(negedge clk);
    slot_valid = 1'b1;
    {slot_chan, slot_frame, slot_data, slot_sig, d4_mode, yellow_tx,
     stuff_all_a, stuff_all_b} = v[29:8];
    @(negedge clk);
    slot_valid = 1'b0;
    check({req, " valid"}, {7'd0, out_valid}, 8'h01);
    check(req, out_data, v[7:0]);
    d4_mode = 0; yellow_tx = 0; stuff_all_a = 0; stuff_all_b = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    slot_valid = 0; slot_chan = 0; slot_frame = 0; slot_data = 0;
    slot_sig = 0; d4_mode = 0; yellow_tx = 0; stuff_all_a = 0; stuff_all_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10: reset state and default processing
    check("R10 out_valid", {7'd0, out_valid}, 8'h00);
    check("R10 out_data", out_data, 8'h00);
    run_slot("R10 default ch1", {5'd1, 4'd1, 8'h00, 5'b0, 8'h02});
    run_slot("R10 default ch2 sig", {5'd2, 4'd6, 8'h80, 1'b1, 4'b0, 8'h81});

    // R1 configuration
    cfg_write(3'd0, 8'h11);
    cfg_write(3'd2, 8'h80);
    cfg_write(3'd3, 8'h42);
    cfg_write(3'd5, 8'h80);
    cfg_write(3'd6, 8'h3C);

    for (int i = 0; i < NV; i++) run_slot("R-table", VEC[i]);

    // R9: no slot -> no valid, data held
    @(negedge clk);
    check("R9 no valid", {7'd0, out_valid}, 8'h00);
    check("R9 hold", out_data, 8'h01);

    // R1: write and slot in the same cycle; ch3 becomes clear
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h15;
    slot_valid = 1'b1; slot_chan = 5'd3; slot_frame = 4'd6;
    slot_data = 8'hAA; slot_sig = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; slot_valid = 1'b0;
    check("R1 same-cycle old value", out_data, 8'hAB);
    run_slot("R1 next slot new value", {5'd3, 4'd6, 8'hAA, 1'b1, 4'b0, 8'hAA});

    // R8: idle code 0x01, sig 0 in frame 6 -> zero -> stuffed
    cfg_write(3'd6, 8'h01);
    run_slot("R8 idle-sig-stuff", {5'd2, 4'd6, 8'hF0, 1'b0, 4'b0, 8'h02});
    run_slot("R2 idle code update", {5'd7, 4'd1, 8'hF0, 1'b0, 4'b0, 8'h01});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule